// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a fully associative translation cache for one processor. A lookup presents a virtual address, the current address-space tag and whether the access is a write. Within the same cycle, and without any clock edge on the path, the block answers with a hit or a miss. On a hit it also returns the physical address, the protection field, a write-protection fault flag, and the referenced and modified bits of the matching slot as they stood before the access.

Every slot carries its own address-space tag, so a context switch needs no flush. A fill port lets an external page walker install a translation after a miss. Two flush controls are provided: one clears every slot, the other clears only the slots that carry one tag. When every slot is valid, a fill evicts the least recently used slot. Recency is tracked exactly over all slots by a pairwise-order matrix. The slot count is a parameter from 2 to 48 and defaults to 16.

Top module: `tlb_asid`

## Requirements
- R1: After reset no slot is valid, so every lookup misses.
- R2: A lookup hits only when a slot is valid, its page number equals `lk_vaddr[31:12]` and its tag equals `lk_asid`. On a miss, `lk_hit`, `lk_fault` and `lk_paddr` are all zero.
- R3: On a hit, `lk_paddr` is the slot's frame number placed above `lk_vaddr[11:0]`, and `lk_prot` is the slot's protection field. Both appear combinationally in the request cycle.
- R4: A hit that is a read sets the slot's referenced bit. A hit that is a write, if it does not fault, sets both the referenced and the modified bits. `lk_ref` and `lk_mod` show the bits as they were before the current access.
- R5: Protection bit 0 set to 1 means the page is writable. A write hit to a slot with bit 0 at 0 raises `lk_fault`, sets only the referenced bit and leaves the modified bit clear. Read hits never fault.
- R6: A fill whose key matches no valid slot goes into the lowest-indexed invalid slot. That slot becomes valid with its referenced and modified bits clear.
- R7: When all slots are valid, a fill replaces the least recently used slot. Hits and fills both count as a use. A fill counts as more recent than a hit in the same cycle. After reset the order is slot 0 oldest and the highest slot newest.
- R8: A fill whose page number and tag match a valid slot overwrites that slot in place, so no two valid slots ever share a key.
- R9: `flush_all` invalidates every slot at the next clock edge.
- R10: `flush_asid_valid` invalidates exactly the slots whose tag equals `flush_asid` and leaves all others intact.
- R11: In a cycle where either flush is asserted, the fill and any referenced, modified or recency update are discarded. `flush_all` has priority over the tag flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_asid | input | 8 | Current address-space tag |
| lk_write | input | 1 | Lookup is a write access |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated physical address |
| lk_fault | output | 1 | Write to a non-writable page |
| lk_prot | output | 2 | Protection field of the hit slot |
| lk_ref | output | 1 | Referenced bit of the hit slot before this access |
| lk_mod | output | 1 | Modified bit of the hit slot before this access |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_asid | input | 8 | Tag of the new translation |
| fill_pfn | input | 20 | Frame number of the new translation |
| fill_prot | input | 2 | Protection field, bit 0 means writable |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_valid | input | 1 | Invalidate the slots carrying `flush_asid` |
| flush_asid | input | 8 | Tag to flush |

## Verification
The assertions check several properties on every cycle. At most one slot matches a lookup. A miss never carries an address or a fault, and a fault only comes with a write hit. A faulting write never sets a modified bit. A fill with no matching key adds exactly one valid slot while free slots remain. A flush never adds slots, and a full flush leaves nothing valid. Exactly one slot is marked least recent. The bench's scenarios, in contrast, show which slot is evicted after long mixes of hits and fills, that the tag flush spares the other tags, and that the referenced and modified bits report correct history across many accesses. To do this the bench compares against its own timestamp model of recency.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int MAX_SLOTS      = 48;
   localparam int PROT_W         = 2;
   localparam int PROT_WRITE_BIT = 0;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int N      = 16,
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8
) (
   input  logic [N-1:0]      valid,
   input  logic [VPN_W-1:0]  slot_vpn  [N],
   input  logic [ASID_W-1:0] slot_asid [N],
   input  logic [VPN_W-1:0]  key_vpn,
   input  logic [ASID_W-1:0] key_asid,
   output logic [N-1:0]      match
);
   for (genvar s = 0; s < N; s++) begin : g_cmp
      assign match[s] = valid[s] && (slot_vpn[s] == key_vpn) && (slot_asid[s] == key_asid);
   end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             use_a,
   input  logic [IDX_W-1:0] idx_a,
   input  logic             use_b,
   input  logic [IDX_W-1:0] idx_b,
   output logic [N-1:0]     oldest
);
   // order_q[r][c] = 1 : slot r was used more recently than slot c
   logic [N-1:0] order_q [N];
   logic [N-1:0] order_d [N];

   always_comb begin
      for (int r = 0; r < N; r++) order_d[r] = order_q[r];
      if (use_a) begin
         for (int r = 0; r < N; r++) begin
            if (IDX_W'(r) == idx_a) begin
               for (int c = 0; c < N; c++) order_d[r][c] = (c != r);
            end else begin
               order_d[r][idx_a] = 1'b0;
            end
         end
      end
      if (use_b) begin
         for (int r = 0; r < N; r++) begin
            if (IDX_W'(r) == idx_b) begin
               for (int c = 0; c < N; c++) order_d[r][c] = (c != r);
            end else begin
               order_d[r][idx_b] = 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) order_q[r][c] <= (r > c);
      end else begin
         for (int r = 0; r < N; r++) order_q[r] <= order_d[r];
      end
   end

   for (genvar s = 0; s < N; s++) begin : g_old
      assign oldest[s] = (order_q[s] == '0);
   end

   AST_LRU_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest) == 1); // R7
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     valid,
   input  logic [N-1:0]     key_match,
   input  logic [N-1:0]     oldest,
   output logic [IDX_W-1:0] slot
);
   logic [IDX_W-1:0] match_idx, free_idx, old_idx;

   always_comb begin
      match_idx = '0;
      old_idx   = '0;
      free_idx  = '0;
      for (int s = 0; s < N; s++) begin
         if (key_match[s]) match_idx = match_idx | IDX_W'(s);
         if (oldest[s])    old_idx   = old_idx   | IDX_W'(s);
      end
      for (int s = N - 1; s >= 0; s--) begin
         if (!valid[s]) free_idx = IDX_W'(s);
      end
      if (|key_match)      slot = match_idx;   // R8
      else if (!(&valid))  slot = free_idx;    // R6
      else                 slot = old_idx;     // R7
   end
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid #(
   parameter int NUM_ENTRIES = 16,
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int PAGE_BITS   = 12,
   parameter int ASID_W      = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       lk_valid,
   input  logic [VA_W-1:0]            lk_vaddr,
   input  logic [ASID_W-1:0]          lk_asid,
   input  logic                       lk_write,
   output logic                       lk_hit,
   output logic [PA_W-1:0]            lk_paddr,
   output logic                       lk_fault,
   output logic [tlb_pkg::PROT_W-1:0] lk_prot,
   output logic                       lk_ref,
   output logic                       lk_mod,
   input  logic                       fill_valid,
   input  logic [VA_W-PAGE_BITS-1:0]  fill_vpn,
   input  logic [ASID_W-1:0]          fill_asid,
   input  logic [PA_W-PAGE_BITS-1:0]  fill_pfn,
   input  logic [tlb_pkg::PROT_W-1:0] fill_prot,
   input  logic                       flush_all,
   input  logic                       flush_asid_valid,
   input  logic [ASID_W-1:0]          flush_asid
);
   import tlb_pkg::*;

   localparam int N     = NUM_ENTRIES;
   localparam int IDX_W = $clog2(N);
   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int PFN_W = PA_W - PAGE_BITS;

   if (NUM_ENTRIES < 2 || NUM_ENTRIES > MAX_SLOTS) begin : g_bad_entries
      $error("tlb_asid: NUM_ENTRIES must be within 2..48");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
      $error("tlb_asid: PAGE_BITS out of range");
   end

   // slot state
   logic [N-1:0]      valid_q, ref_q, mod_q;
   logic [VPN_W-1:0]  vpn_q  [N];
   logic [ASID_W-1:0] asid_q [N];
   logic [PFN_W-1:0]  pfn_q  [N];
   logic [PROT_W-1:0] prot_q [N];

   logic [N-1:0]     hit_raw, hit_oh, fill_match, kill_mask, oldest;
   logic [IDX_W-1:0] hit_idx, vic_idx;
   logic [PFN_W-1:0] pfn_sel;
   logic [PROT_W-1:0] prot_sel;
   logic             ref_sel, mod_sel, any_flush, upd_ok;

   tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_lookup (
      .valid(valid_q), .slot_vpn(vpn_q), .slot_asid(asid_q),
      .key_vpn(lk_vaddr[VA_W-1:PAGE_BITS]), .key_asid(lk_asid), .match(hit_raw));

   tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_fill (
      .valid(valid_q), .slot_vpn(vpn_q), .slot_asid(asid_q),
      .key_vpn(fill_vpn), .key_asid(fill_asid), .match(fill_match));

   assign hit_oh    = hit_raw & {N{lk_valid}};
   assign any_flush = flush_all | flush_asid_valid;
   assign upd_ok    = !any_flush;

   always_comb begin
      hit_idx  = '0;
      pfn_sel  = '0;
      prot_sel = '0;
      ref_sel  = 1'b0;
      mod_sel  = 1'b0;
      for (int s = 0; s < N; s++) begin
         if (hit_oh[s]) begin
            hit_idx  = hit_idx | IDX_W'(s);
            pfn_sel  = pfn_sel | pfn_q[s];
            prot_sel = prot_sel | prot_q[s];
            ref_sel  = ref_sel | ref_q[s];
            mod_sel  = mod_sel | mod_q[s];
         end
      end
   end

   assign lk_hit   = |hit_oh;
   assign lk_paddr = lk_hit ? {pfn_sel, lk_vaddr[PAGE_BITS-1:0]} : '0;
   assign lk_prot  = prot_sel;
   assign lk_ref   = ref_sel;
   assign lk_mod   = mod_sel;
   assign lk_fault = lk_hit && lk_write && !prot_sel[PROT_WRITE_BIT];

   for (genvar s = 0; s < N; s++) begin : g_kill
      assign kill_mask[s] = (asid_q[s] == flush_asid);
   end

   tlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
      .valid(valid_q), .key_match(fill_match), .oldest(oldest), .slot(vic_idx));

   tlb_lru #(.N(N), .IDX_W(IDX_W)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .use_a(lk_hit && upd_ok), .idx_a(hit_idx),
      .use_b(fill_valid && upd_ok), .idx_b(vic_idx),
      .oldest(oldest));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         ref_q   <= '0;
         mod_q   <= '0;
         for (int s = 0; s < N; s++) begin
            vpn_q[s]  <= '0;
            asid_q[s] <= '0;
            pfn_q[s]  <= '0;
            prot_q[s] <= '0;
         end
      end else if (flush_all) begin
         valid_q <= '0;                                   // R9
      end else if (flush_asid_valid) begin
         valid_q <= valid_q & ~kill_mask;                 // R10
      end else begin
         if (lk_hit) begin
            ref_q[hit_idx] <= 1'b1;                       // R4
            if (!lk_fault && lk_write) mod_q[hit_idx] <= 1'b1;
         end
         if (fill_valid) begin                            // later write wins on same slot
            valid_q[vic_idx] <= 1'b1;
            ref_q[vic_idx]   <= 1'b0;
            mod_q[vic_idx]   <= 1'b0;
            vpn_q[vic_idx]   <= fill_vpn;
            asid_q[vic_idx]  <= fill_asid;
            pfn_q[vic_idx]   <= fill_pfn;
            prot_q[vic_idx]  <= fill_prot;
         end
      end
   end

   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_raw)); // R8
   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_paddr == '0) && !lk_fault); // R2
   AST_FAULT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> lk_hit && lk_write); // R5
   AST_FAULT_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault && upd_ok |=> (mod_q & ~$past(mod_q)) == '0); // R5
   AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> valid_q == '0); // R9
   AST_FLUSH_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      any_flush |=> $countones(valid_q) <= $countones($past(valid_q))); // R11
   AST_FILL_TAKES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid && upd_ok && (fill_match == '0) && !(&valid_q)
      |=> $countones(valid_q) == $countones($past(valid_q)) + 1); // R6
endmodule

// File: tb/tlb_asid_bench.sv
module tlb_asid_bench;
   localparam int NE = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 0, lk_write = 0;
   logic [31:0] lk_vaddr = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_hit, lk_fault, lk_ref, lk_mod;
   logic [31:0] lk_paddr;
   logic [1:0]  lk_prot;
   logic        fill_valid = 0;
   logic [19:0] fill_vpn = '0, fill_pfn = '0;
   logic [7:0]  fill_asid = '0;
   logic [1:0]  fill_prot = '0;
   logic        flush_all = 0, flush_asid_valid = 0;
   logic [7:0]  flush_asid = '0;

   int checks = 0, failures = 0;
   bit done = 0;

   // reference model
   bit          m_val [NE];
   bit          m_ref [NE];
   bit          m_mod [NE];
   logic [19:0] m_vpn [NE];
   logic [7:0]  m_asid [NE];
   logic [19:0] m_pfn [NE];
   logic [1:0]  m_prot [NE];
   int          m_stamp [NE];
   int          m_time;

   always #5 clk = ~clk;

   tlb_asid u_tlb_asid (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_write(lk_write),
      .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_fault(lk_fault), .lk_prot(lk_prot),
      .lk_ref(lk_ref), .lk_mod(lk_mod),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
      .fill_pfn(fill_pfn), .fill_prot(fill_prot),
      .flush_all(flush_all), .flush_asid_valid(flush_asid_valid), .flush_asid(flush_asid));

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int m_find(logic [19:0] vpn, logic [7:0] asid);
      for (int s = 0; s < NE; s++)
         if (m_val[s] && m_vpn[s] == vpn && m_asid[s] == asid) return s;
      return -1;
   endfunction

   function automatic int m_victim();
      int best;
      int k = m_find(fill_vpn, fill_asid);
      if (k >= 0) return k;
      for (int s = 0; s < NE; s++) if (!m_val[s]) return s;
      best = 0;
      for (int s = 1; s < NE; s++) if (m_stamp[s] < m_stamp[best]) best = s;
      return best;
   endfunction

   task automatic m_reset();
      for (int s = 0; s < NE; s++) begin
         m_val[s] = 0; m_ref[s] = 0; m_mod[s] = 0; m_stamp[s] = s;
      end
      m_time = NE;
   endtask

   task automatic compare();
      int h;
      if (!lk_valid) return;
      h = m_find(lk_vaddr[31:12], lk_asid);
      check("R2", "hit", 32'(lk_hit), 32'(h >= 0));
      if (h >= 0) begin
         check("R3", "paddr", lk_paddr, {m_pfn[h], lk_vaddr[11:0]});
         check("R3", "prot", 32'(lk_prot), 32'(m_prot[h]));
         check("R4", "ref", 32'(lk_ref), 32'(m_ref[h]));
         check("R4", "mod", 32'(lk_mod), 32'(m_mod[h]));
         check("R5", "fault", 32'(lk_fault), 32'(lk_write && !m_prot[h][0]));
      end else begin
         check("R2", "miss paddr", lk_paddr, 32'h0);
      end
   endtask

   task automatic m_update();
      int h, v;
      if (flush_all) begin
         for (int s = 0; s < NE; s++) m_val[s] = 0;
      end else if (flush_asid_valid) begin
         for (int s = 0; s < NE; s++) if (m_asid[s] == flush_asid) m_val[s] = 0;
      end else begin
         v = m_victim();
         h = lk_valid ? m_find(lk_vaddr[31:12], lk_asid) : -1;
         if (h >= 0) begin
            m_time++; m_stamp[h] = m_time; m_ref[h] = 1;
            if (lk_write && m_prot[h][0]) m_mod[h] = 1;
         end
         if (fill_valid) begin
            m_val[v] = 1; m_ref[v] = 0; m_mod[v] = 0;
            m_vpn[v] = fill_vpn; m_asid[v] = fill_asid;
            m_pfn[v] = fill_pfn; m_prot[v] = fill_prot;
            m_time++; m_stamp[v] = m_time;
         end
      end
   endtask

   // called at a falling edge with inputs already driven
   task automatic step();
      #2;
      compare();
      @(posedge clk);
      m_update();
      @(negedge clk);
   endtask

   task automatic idle();
      lk_valid = 0; lk_write = 0; fill_valid = 0; flush_all = 0; flush_asid_valid = 0;
   endtask

   task automatic fill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] pfn, logic [1:0] prot);
      idle();
      fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn; fill_prot = prot;
      step();
      idle();
   endtask

   task automatic look(logic [19:0] vpn, logic [7:0] asid, logic wr);
      lk_valid = 1; lk_write = wr; lk_vaddr = {vpn, 12'($urandom_range(0, 4095))}; lk_asid = asid;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4051));
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: empty after reset
      for (int k = 0; k < 4; k++) begin
         look(20'(k * 7), 8'(k), 1'b0);
         check("R1", "hit after reset", 32'(lk_hit), 32'h0);
         step();
      end
      idle();

      // R3 / R4: translate and track referenced/modified
      fill(20'h00abc, 8'd1, 20'h12345, 2'b01);
      lk_vaddr = 32'h00abc7f3; lk_asid = 8'd1; lk_valid = 1; lk_write = 0; #1;
      check("R3", "paddr directed", lk_paddr, 32'h123457f3);
      check("R4", "ref before first use", 32'(lk_ref), 32'h0);
      step();
      lk_write = 1; #1;
      check("R4", "ref after read", 32'(lk_ref), 32'h1);
      check("R4", "mod before write", 32'(lk_mod), 32'h0);
      step();
      lk_write = 0; #1;
      check("R4", "mod after write", 32'(lk_mod), 32'h1);
      step();
      // R2: same page, other tag
      look(20'h00abc, 8'd2, 1'b0);
      check("R2", "other tag misses", 32'(lk_hit), 32'h0);
      step();

      // R5: read-only page
      fill(20'h00def, 8'd1, 20'h0beef, 2'b10);
      look(20'h00def, 8'd1, 1'b1);
      check("R5", "fault on ro write", 32'(lk_fault), 32'h1);
      step();
      look(20'h00def, 8'd1, 1'b0);
      check("R5", "mod stays clear", 32'(lk_mod), 32'h0);
      check("R5", "ref set by faulting write", 32'(lk_ref), 32'h1);
      check("R5", "no fault on read", 32'(lk_fault), 32'h0);
      step();

      // R8: refill same key overwrites in place
      fill(20'h00abc, 8'd1, 20'h55555, 2'b01);
      look(20'h00abc, 8'd1, 1'b0);
      check("R8", "refill new frame", lk_paddr[31:12], 32'h55555);
      check("R8", "refill clears mod", 32'(lk_mod), 32'h0);
      step();

      // R11: fill during a flush is dropped
      idle();
      flush_asid_valid = 1; flush_asid = 8'd9;
      fill_valid = 1; fill_vpn = 20'h00777; fill_asid = 8'd3; fill_pfn = 20'h1; fill_prot = 2'b01;
      step();
      idle();
      look(20'h00777, 8'd3, 1'b0);
      check("R11", "fill dropped in flush", 32'(lk_hit), 32'h0);
      step();

      // R10: tag flush spares other tags
      fill(20'h00100, 8'd4, 20'h00100, 2'b01);
      idle(); flush_asid_valid = 1; flush_asid = 8'd1; step(); idle();
      look(20'h00abc, 8'd1, 1'b0);
      check("R10", "flushed tag gone", 32'(lk_hit), 32'h0);
      step();
      look(20'h00100, 8'd4, 1'b0);
      check("R10", "other tag kept", 32'(lk_hit), 32'h1);
      step();

      // R9: flush everything
      idle(); flush_all = 1; step(); idle();
      look(20'h00100, 8'd4, 1'b0);
      check("R9", "flush all", 32'(lk_hit), 32'h0);
      step();

      // R6 / R7: fill all slots, touch slot 0, then evict slot 1
      for (int k = 0; k < NE; k++) fill(20'(16'h200 + k), 8'd5, 20'(k), 2'b01);
      look(20'h00200, 8'd5, 1'b0); step(); idle();
      fill(20'h00300, 8'd5, 20'hfffff, 2'b01);
      look(20'h00201, 8'd5, 1'b0);
      check("R7", "lru evicted", 32'(lk_hit), 32'h0);
      step();
      look(20'h00200, 8'd5, 1'b0);
      check("R7", "recent survives", 32'(lk_hit), 32'h1);
      step();
      idle(); flush_asid_valid = 1; flush_asid = 8'd5; step(); idle();
      fill(20'h00400, 8'd6, 20'h00400, 2'b01);
      look(20'h00400, 8'd6, 1'b0);
      check("R6", "fill after flush lands", 32'(lk_hit), 32'h1);
      step();

      // random traffic checked against model
      for (int k = 0; k < 6000; k++) begin
         int r = $urandom_range(0, 99);
         idle();
         lk_valid   = ($urandom_range(0, 9) < 8);
         lk_write   = $urandom_range(0, 1);
         lk_vaddr   = {20'($urandom_range(0, 23)), 12'($urandom_range(0, 4095))};
         lk_asid    = 8'($urandom_range(0, 2));
         fill_valid = ($urandom_range(0, 9) < 4);
         fill_vpn   = 20'($urandom_range(0, 23));
         fill_asid  = 8'($urandom_range(0, 2));
         fill_pfn   = 20'($urandom);
         fill_prot  = 2'($urandom_range(0, 3));
         flush_all  = (r == 0);
         flush_asid_valid = (r >= 1 && r <= 2);
         flush_asid = 8'($urandom_range(0, 2));
         step();
      end
      idle();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule